// File: doc/BRIEF.md
# Eight-Kilobyte Window Bank Mapper

This block sits between a CPU, a video controller and two banked ROMs. It cuts the CPU's 32 KB program window (0x8000 to 0xFFFF) into four 8 KB slots and its 8 KB pattern-bus range into 2 KB and 1 KB slots. It turns each address into a physical ROM address by replacing the slot bits with a bank number. Software changes the bank numbers by writing to a small register file that lives in the same address window. Those registers can only be written: CPU writes into the window never reach ROM.

The registers come in pairs. An even address holds the low register of a pair and an odd address holds the high one. A write to the select register (the low register of the first pair) chooses which of eight bank registers the next data write will load. The same write also sets two layout modes. One mode swaps which program slot is switchable and which is tied to the second-last bank. The other swaps the 2 KB and 1 KB halves of the pattern range. The low register of the second pair holds the nametable mirroring select. Writes to the high register of the second pair, and to the 0xC000 and 0xE000 pairs, are decoded and then dropped.

Top module: `bank_mapper`

## Requirements
- R1: After reset every register is zero: select index 0, both modes off, all eight bank registers 0, and mirroring vertical (`mirror_horiz` = 0).
- R2: A CPU address in 0xE000–0xFFFF always maps to the last program bank (all ones in the bank field), whatever the register contents.
- R3: With program swap off, slot 0x8000 uses bank register 6, slot 0xA000 uses bank register 7, and slot 0xC000 uses the second-last bank. The output is {bank, cpu_addr[12:0]}.
- R4: With program swap on (select bit 6 = 1), slot 0x8000 uses the second-last bank, slot 0xC000 uses bank register 6, and slot 0xA000 still uses bank register 7.
- R5: With pattern inversion off, ppu_addr 0x0000–0x07FF uses bank register 0 and 0x0800–0x0FFF uses bank register 1. These are 2 KB banks: the low bit of the stored number is replaced by ppu_addr[10]. The output is {bank, ppu_addr[9:0]}.
- R6: With pattern inversion off, the four 1 KB slots at 0x1000, 0x1400, 0x1800 and 0x1C00 use bank registers 2, 3, 4 and 5.
- R7: With pattern inversion on (select bit 7 = 1), the 2 KB pair serves 0x1000–0x1FFF and the 1 KB group serves 0x0000–0x0FFF, each in the same order as before.
- R8: A write to an even address in 0x8000–0x9FFF stores the target index from data[2:0], program swap from data[6] and pattern inversion from data[7]. A write to an odd address in that range loads data into the bank register that the stored index names.
- R9: A write to an even address in 0xA000–0xBFFF sets `mirror_horiz` to data[0] on the next cycle. Writes to odd addresses in 0xA000–0xBFFF, and any write to 0xC000–0xFFFF, change no mapping and no mirroring.
- R10: Bank numbers are masked to the ROM sizes. Program banks keep their low PRG_BANK_W bits and pattern banks keep their low CHR_BANK_W bits.
- R11: A cycle with `cpu_wr` low, or with cpu_addr[15] = 0, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr | input | 13 | Pattern-bus address, 0x0000–0x1FFF |
| prg_rom_addr | output | PRG_BANK_W+13 | Banked program ROM address |
| chr_rom_addr | output | CHR_BANK_W+10 | Banked pattern ROM address |
| mirror_horiz | output | 1 | Mirroring select: 0 vertical, 1 horizontal |

## Verification
The bench builds the mapper with PRG_BANK_W = 4 (16 program banks) and CHR_BANK_W = 7 (128 pattern banks). Both are narrower than the 8-bit data bus, so random bank bytes reach the masking of R10 on both sides. The second-last and last program banks (14 and 15) are also small enough that random bank numbers sometimes collide with them. The translation of both the swapped and unswapped layouts therefore has to be bit-exact.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int DATA_W        = 8;
    localparam int NUM_BANK_REGS = 8;
    localparam int IDX_W         = $clog2(NUM_BANK_REGS);
    localparam int PRG_OFS_W     = 13;
    localparam int CHR_OFS_W     = 10;

    // Bank register indices with a fixed role in the layouts
    localparam logic [IDX_W-1:0] IDX_PRG_A = 3'd6;
    localparam logic [IDX_W-1:0] IDX_PRG_B = 3'd7;

    typedef logic [DATA_W-1:0] bank_t;

    typedef struct packed {
        logic             chr_inv;
        logic             prg_swap;
        logic [IDX_W-1:0] target;
    } sel_t;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_SELECT,
        WR_BANK,
        WR_MIRROR,
        WR_IGNORED
    } wr_kind_e;

    function automatic sel_t unpack_sel(input bank_t d);
        sel_t s;
        s.chr_inv  = d[7];
        s.prg_swap = d[6];
        s.target   = d[IDX_W-1:0];
        return s;
    endfunction

    function automatic wr_kind_e classify(input logic wr, input logic [15:0] a);
        if (!wr || !a[15])              return WR_NONE;
        unique case (a[14:13])
            2'b00:   return a[0] ? WR_BANK : WR_SELECT;
            2'b01:   return a[0] ? WR_IGNORED : WR_MIRROR;
            default: return WR_IGNORED;
        endcase
    endfunction

endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
    import mapper_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic [15:0]                       cpu_addr,
    input  bank_t                             cpu_data,
    input  logic                              cpu_wr,
    output sel_t                              sel_q,
    output logic [NUM_BANK_REGS-1:0][DATA_W-1:0] bank_q,
    output logic                              mirror_q
);

    wr_kind_e kind;

    always_comb kind = classify(cpu_wr, cpu_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= '0;
            mirror_q <= 1'b0;
        end else begin
            if (kind == WR_SELECT) sel_q    <= unpack_sel(cpu_data);
            if (kind == WR_MIRROR) mirror_q <= cpu_data[0];
        end
    end

    for (genvar i = 0; i < NUM_BANK_REGS; i++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                bank_q[i] <= '0;
            else if (kind == WR_BANK && sel_q.target == IDX_W'(i))
                bank_q[i] <= cpu_data;
        end
    end

endmodule

// File: rtl/mapper_prg_xlat.sv
module mapper_prg_xlat
    import mapper_pkg::*;
#(
    parameter int PRG_BANK_W = 5
) (
    input  logic [14:0]                     cpu_ofs,
    input  logic                            prg_swap,
    input  bank_t                           bank_a,
    input  bank_t                           bank_b,
    output logic [PRG_BANK_W+PRG_OFS_W-1:0] rom_addr
);

    localparam logic [PRG_BANK_W-1:0] LAST_BANK   = '1;
    localparam logic [PRG_BANK_W-1:0] SECOND_LAST = LAST_BANK - 1'b1;

    logic [PRG_BANK_W-1:0] bank;

    always_comb begin
        unique case (cpu_ofs[14:13])
            2'd0: bank = prg_swap ? SECOND_LAST : bank_a[PRG_BANK_W-1:0];
            2'd1: bank = bank_b[PRG_BANK_W-1:0];
            2'd2: bank = prg_swap ? bank_a[PRG_BANK_W-1:0] : SECOND_LAST;
            default: bank = LAST_BANK;
        endcase
        rom_addr = {bank, cpu_ofs[PRG_OFS_W-1:0]};
    end

endmodule

// File: rtl/mapper_chr_xlat.sv
module mapper_chr_xlat
    import mapper_pkg::*;
#(
    parameter int CHR_BANK_W = 8
) (
    input  logic [12:0]                     ppu_addr,
    input  logic                            chr_inv,
    input  logic [5:0][DATA_W-1:0]          banks,
    output logic [CHR_BANK_W+CHR_OFS_W-1:0] rom_addr
);

    logic                  big_half;
    logic [CHR_BANK_W-1:0] pick;
    logic [CHR_BANK_W-1:0] bank;

    always_comb begin
        big_half = ~(ppu_addr[12] ^ chr_inv);
        if (big_half) begin
            pick = banks[ppu_addr[11]][CHR_BANK_W-1:0];
            bank = {pick[CHR_BANK_W-1:1], ppu_addr[10]};
        end else begin
            pick = banks[3'd2 + {1'b0, ppu_addr[11:10]}][CHR_BANK_W-1:0];
            bank = pick;
        end
        rom_addr = {bank, ppu_addr[CHR_OFS_W-1:0]};
    end

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import mapper_pkg::*;
#(
    parameter int PRG_BANK_W = 5,
    parameter int CHR_BANK_W = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [15:0]                     cpu_addr,
    input  logic [7:0]                      cpu_data,
    input  logic                            cpu_wr,
    input  logic [12:0]                     ppu_addr,
    output logic [PRG_BANK_W+12:0]          prg_rom_addr,
    output logic [CHR_BANK_W+9:0]           chr_rom_addr,
    output logic                            mirror_horiz
);

    sel_t                                 sel_q;
    logic [NUM_BANK_REGS-1:0][DATA_W-1:0] bank_q;
    logic [5:0][DATA_W-1:0]               chr_banks;

    mapper_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_wr   (cpu_wr),
        .sel_q    (sel_q),
        .bank_q   (bank_q),
        .mirror_q (mirror_horiz)
    );

    mapper_prg_xlat #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
        .cpu_ofs  (cpu_addr[14:0]),
        .prg_swap (sel_q.prg_swap),
        .bank_a   (bank_q[IDX_PRG_A]),
        .bank_b   (bank_q[IDX_PRG_B]),
        .rom_addr (prg_rom_addr)
    );

    always_comb chr_banks = bank_q[5:0];

    mapper_chr_xlat #(.CHR_BANK_W(CHR_BANK_W)) u_chr (
        .ppu_addr (ppu_addr),
        .chr_inv  (sel_q.chr_inv),
        .banks    (chr_banks),
        .rom_addr (chr_rom_addr)
    );

endmodule

module bank_mapper_chk #(
    parameter int PRG_BANK_W = 5,
    parameter int CHR_BANK_W = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic [15:0]            cpu_addr,
    input logic [7:0]             cpu_data,
    input logic                   cpu_wr,
    input logic [12:0]            ppu_addr,
    input logic [PRG_BANK_W+12:0] prg_rom_addr,
    input logic [CHR_BANK_W+9:0]  chr_rom_addr,
    input logic                   mirror_horiz
);

    // R2
    top_slot_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] == 3'b111) |-> (&prg_rom_addr[PRG_BANK_W+12:13]));

    // R9
    mirror_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:13] == 3'b101 && !cpu_addr[0])
        |=> (mirror_horiz == $past(cpu_data[0])));

    // R11
    mirror_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr && cpu_addr[15:13] == 3'b101 && !cpu_addr[0])
        |=> $stable(mirror_horiz));

    // R1
    reset_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mirror_horiz == 1'b0));

    // R3
    prg_offset_chk: assert property (@(posedge clk) disable iff (rst)
        prg_rom_addr[12:0] == cpu_addr[12:0]);

    // R5
    chr_offset_chk: assert property (@(posedge clk) disable iff (rst)
        chr_rom_addr[9:0] == ppu_addr[9:0]);

endmodule

bind bank_mapper bank_mapper_chk #(
    .PRG_BANK_W (PRG_BANK_W),
    .CHR_BANK_W (CHR_BANK_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_addr     (cpu_addr),
    .cpu_data     (cpu_data),
    .cpu_wr       (cpu_wr),
    .ppu_addr     (ppu_addr),
    .prg_rom_addr (prg_rom_addr),
    .chr_rom_addr (chr_rom_addr),
    .mirror_horiz (mirror_horiz)
);

// File: tb/bank_mapper_bench.sv
`timescale 1ns/1ps
module bank_mapper_bench;

    localparam int PW = 4;
    localparam int CW = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [15:0]       cpu_addr = 16'h0;
    logic [7:0]        cpu_data = 8'h0;
    logic              cpu_wr = 1'b0;
    logic [12:0]       ppu_addr = 13'h0;
    logic [PW+12:0]    prg_rom_addr;
    logic [CW+9:0]     chr_rom_addr;
    logic              mirror_horiz;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model state
    logic [7:0] m_bank [8];
    logic [2:0] m_tgt;
    logic       m_swap, m_inv, m_mir;

    always #4 clk = ~clk;

    bank_mapper #(.PRG_BANK_W(PW), .CHR_BANK_W(CW)) u_bank_mapper (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_rom_addr(prg_rom_addr),
        .chr_rom_addr(chr_rom_addr), .mirror_horiz(mirror_horiz)
    );

    function automatic logic [PW+12:0] exp_prg(input logic [15:0] a);
        logic [PW-1:0] last, b;
        last = '1;
        case (a[14:13])
            2'd0: b = m_swap ? last - 1'b1 : m_bank[6][PW-1:0];
            2'd1: b = m_bank[7][PW-1:0];
            2'd2: b = m_swap ? m_bank[6][PW-1:0] : last - 1'b1;
            default: b = last;
        endcase
        return {b, a[12:0]};
    endfunction

    function automatic logic [CW+9:0] exp_chr(input logic [12:0] p);
        logic [7:0] b;
        if ((p[12] ^ m_inv) == 1'b0) begin
            b = m_bank[p[11]];
            b[0] = p[10];
        end else begin
            b = m_bank[2 + p[11:10]];
        end
        return {b[CW-1:0], p[9:0]};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_bank[i] = 8'h0;
        m_tgt = 3'd0; m_swap = 1'b0; m_inv = 1'b0; m_mir = 1'b0;
    endtask

    task automatic model_write(input logic wr, input logic [15:0] a, input logic [7:0] d);
        if (wr && a[15]) begin
            case (a[14:13])
                2'd0: if (!a[0]) begin
                          m_tgt = d[2:0]; m_swap = d[6]; m_inv = d[7];
                      end else m_bank[m_tgt] = d;
                2'd1: if (!a[0]) m_mir = d[0];
                default: ;
            endcase
        end
    endtask

    task automatic bus_cycle(input logic wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = wr;
        @(posedge clk);
        model_write(wr, a, d);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic check_at(input logic [15:0] a, input logic [12:0] p, input string tag);
        @(negedge clk);
        cpu_addr = a; ppu_addr = p;
        #1;
        checks++;
        if (prg_rom_addr !== exp_prg(a)) begin
            fails++;
            $display("FAIL %s prg addr=%h actual=%h expected=%h", tag, a, prg_rom_addr, exp_prg(a));
        end
        checks++;
        if (chr_rom_addr !== exp_chr(p)) begin
            fails++;
            $display("FAIL %s chr addr=%h actual=%h expected=%h", tag, p, chr_rom_addr, exp_chr(p));
        end
        checks++;
        if (mirror_horiz !== m_mir) begin
            fails++;
            $display("FAIL %s mirror actual=%b expected=%b", tag, mirror_horiz, m_mir);
        end
    endtask

    task automatic sweep(input string tag);
        for (int s = 0; s < 4; s++)
            for (int q = 0; q < 8; q++)
                check_at(16'h8000 | 16'(s << 13) | 16'(q * 3 + 1),
                         13'(q << 10) | 13'h155, tag);
    endtask

    initial begin
        model_reset();
        void'($urandom(32'h1357));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        check_at(16'h8000, 13'h0000, "R1");
        check_at(16'hC123, 13'h1C00, "R1");

        // R8 + R3: load bank registers through select/data pairs
        for (int i = 0; i < 8; i++) begin
            bus_cycle(1'b1, 16'h8000, 8'(i));
            bus_cycle(1'b1, 16'h8001, 8'(8'h11 * (i + 1)));
        end
        sweep("R3_R5_R6_R8");

        // R2: top slot fixed
        check_at(16'hFFFF, 13'h1FFF, "R2");

        // R4 + R7: both modes on
        bus_cycle(1'b1, 16'h8000, 8'hC6);
        sweep("R4_R7");

        // R4: swap only
        bus_cycle(1'b1, 16'h9FFE, 8'h40);
        sweep("R4");

        // R10: masking of over-range bank numbers
        bus_cycle(1'b1, 16'h8000, 8'h06);
        bus_cycle(1'b1, 16'h8001, 8'hFF);
        bus_cycle(1'b1, 16'h8000, 8'h02);
        bus_cycle(1'b1, 16'h8001, 8'hFF);
        check_at(16'h8000, 13'h1000, "R10");

        // R9: mirroring set, then ignored writes
        bus_cycle(1'b1, 16'hA000, 8'h01);
        check_at(16'hA000, 13'h0400, "R9");
        bus_cycle(1'b1, 16'hA001, 8'h00);
        bus_cycle(1'b1, 16'hC000, 8'h00);
        bus_cycle(1'b1, 16'hE001, 8'hFF);
        check_at(16'h8000, 13'h1000, "R9");

        // R11: writes with strobe low or below the window
        bus_cycle(1'b0, 16'h8001, 8'h33);
        bus_cycle(1'b1, 16'h0001, 8'h44);
        bus_cycle(1'b1, 16'h2000, 8'h00);
        check_at(16'h8000, 13'h1000, "R11");

        // random traffic against the model
        for (int n = 0; n < 600; n++) begin
            logic [15:0] a;
            logic        w;
            a = 16'($urandom);
            if (($urandom % 8) != 0) a[15] = 1'b1;
            if (($urandom % 2) == 0) a[14] = 1'b0;
            w = (($urandom % 6) != 0);
            bus_cycle(w, a, 8'($urandom));
            check_at(16'($urandom), 13'($urandom), "R3_R4_R5_R6_R7_R10_R11");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule